// File: doc/BRIEF.md
# Flag-Producing 8-bit ALU

This block is the arithmetic-logic stage of an accumulator machine with 8-bit data. Each cycle it takes the accumulator, a second operand, the current five-bit flag word and a four-bit operation code. It computes the new accumulator and flag word. The block covers binary add and subtract, with or without the incoming carry or borrow, the three bitwise operations, compare, four rotates, complement, two carry-flag operations and a decimal-adjust step for packed BCD sums.

The arithmetic itself is combinational. The accumulator and flag outputs are held in registers, so a result appears one clock after its operands. The surrounding core feeds `acc_o` and `flags_o` back as the next operation's `acc_i` and `flags_i`. Register storage, instruction sequencing and operand fetch belong to the surrounding core.

Flag word layout, used on `flags_i` and `flags_o`:

| Bit | Flag |
|-----|------|
| 0 | carry |
| 1 | parity |
| 2 | auxiliary (nibble) carry |
| 3 | zero |
| 4 | sign |

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `acc_o` and `flags_o` are all zeros.
- R2: ADD (code 0) and ADC (code 1) produce a + b + c, where c is 0 for ADD and `flags_i[0]` for ADC. The carry flag is bit 8 of the sum. The auxiliary flag is the carry out of bit 3.
- R3: SUB (code 2) and SBB (code 3) produce a - b - c, where c is 0 for SUB and `flags_i[0]` for SBB. The carry flag is set when b + c exceeds a. The auxiliary flag is set when b[3:0] + c exceeds a[3:0].
- R4: CMP (code 7) produces every flag exactly as SUB does, and `acc_o` equals the incoming accumulator.
- R5: AND (code 4) produces a & b, clears carry, and sets the auxiliary flag to a[3] OR b[3].
- R6: XOR (code 5) and OR (code 6) produce a ^ b and a | b, and clear both carry and auxiliary flags.
- R7: For codes 0 to 7 and 15, zero (bit 3) is set for a zero result, sign (bit 4) equals result bit 7, and parity (bit 1) is set for an even count of 1 bits. For compare, the result here is the difference.
- R8: RLC (8) rotates left with bit 7 into bit 0 and into carry. RRC (9) rotates right with bit 0 into bit 7 and into carry. RAL (10) shifts the old carry into bit 0 and bit 7 into carry. RAR (11) shifts the old carry into bit 7 and bit 0 into carry. Flag bits 4..1 pass through unchanged.
- R9: CMA (code 12) inverts the accumulator and passes all five flags through unchanged.
- R10: STC (code 13) sets carry and CMC (code 14) inverts carry. Both leave the accumulator and flag bits 4..1 unchanged.
- R11: DAA (code 15) first adds 0x06 if a[3:0] > 9 or the auxiliary flag is set. The auxiliary flag out is the carry out of bit 3 of that addition. It then adds 0x60 if the intermediate high nibble is > 9, the carry flag is set, or the first addition carried out of bit 7. Carry out is set exactly when the 0x60 step is taken.
- R12: Outputs change only at a rising clock edge and reflect the inputs present at that edge (one-cycle latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | active-low synchronous reset |
| op_i | input | 4 | operation code |
| acc_i | input | 8 | current accumulator |
| opnd_i | input | 8 | second operand |
| flags_i | input | 5 | current flag word |
| acc_o | output | 8 | registered new accumulator |
| flags_o | output | 5 | registered new flag word |

## Verification
The bench targets the carry and auxiliary boundaries: 0xFF + 0x01, 0x0F + 0x01 and a subtract with an incoming borrow that exactly equals the minuend. A design with swapped borrow polarity or a missing carry-in would show a wrong carry or a non-zero result there. For decimal adjust it uses 0x9A, 0xFA, 0x99 and a forced auxiliary flag. A design that tested the high nibble before the low correction, or lost the intermediate overflow, would return a wrong BCD digit or drop the carry. Rotates are driven with both carry-in values, so a swap of the circular and through-carry forms shows in bit 0 or bit 7. Compare, complement and the carry-flag operations are checked for an accumulator or flag that moves when it must hold.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned NIB_W  = DATA_W / 2;
    localparam int unsigned FLAG_N = 5;

    localparam int unsigned FL_CY  = 0;
    localparam int unsigned FL_PAR = 1;
    localparam int unsigned FL_AUX = 2;
    localparam int unsigned FL_Z   = 3;
    localparam int unsigned FL_S   = 4;

    localparam logic [NIB_W-1:0]  DEC_LIMIT = NIB_W'(9);
    localparam logic [DATA_W-1:0] ADJ_LO    = DATA_W'(8'h06);
    localparam logic [DATA_W-1:0] ADJ_HI    = DATA_W'(8'h60);

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_AND = 4'd4,
        OP_XOR = 4'd5,
        OP_OR  = 4'd6,
        OP_CMP = 4'd7,
        OP_RLC = 4'd8,
        OP_RRC = 4'd9,
        OP_RAL = 4'd10,
        OP_RAR = 4'd11,
        OP_CMA = 4'd12,
        OP_STC = 4'd13,
        OP_CMC = 4'd14,
        OP_DAA = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [FLAG_N-1:0] flg;
    } alu_state_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o,
    output logic              ac_o
);
    logic [DATA_W:0] wide;
    logic [NIB_W:0]  low;

    always_comb begin
        if (sub_i) begin
            wide = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, cin_i};
            low  = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]}
                   - {{NIB_W{1'b0}}, cin_i};
        end else begin
            wide = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
            low  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]}
                   + {{NIB_W{1'b0}}, cin_i};
        end
        res_o = wide[DATA_W-1:0];
        cy_o  = wide[DATA_W];
        ac_o  = low[NIB_W];
    end
endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic              cy_i,
    input  logic [1:0]        mode_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o
);
    logic        go_right;
    logic        thru_cy;
    logic        fill;

    assign go_right = mode_i[0];
    assign thru_cy  = mode_i[1];

    always_comb begin
        if (go_right) begin
            fill  = thru_cy ? cy_i : a_i[0];
            res_o = {fill, a_i[DATA_W-1:1]};
            cy_o  = a_i[0];
        end else begin
            fill  = thru_cy ? cy_i : a_i[DATA_W-1];
            res_o = {a_i[DATA_W-2:0], fill};
            cy_o  = a_i[DATA_W-1];
        end
    end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic              cy_i,
    input  logic              ac_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o,
    output logic              ac_o
);
    logic            lo_fix;
    logic            hi_fix;
    logic [DATA_W:0] step1;
    logic [NIB_W:0]  low_sum;

    always_comb begin
        lo_fix  = (a_i[NIB_W-1:0] > DEC_LIMIT) || ac_i;
        step1   = {1'b0, a_i} + {1'b0, (lo_fix ? ADJ_LO : '0)};
        low_sum = {1'b0, a_i[NIB_W-1:0]} + {1'b0, (lo_fix ? ADJ_LO[NIB_W-1:0] : '0)};
        ac_o    = low_sum[NIB_W];
        hi_fix  = (step1[DATA_W-1:NIB_W] > DEC_LIMIT) || cy_i || step1[DATA_W];
        res_o   = step1[DATA_W-1:0] + (hi_fix ? ADJ_HI : '0);
        cy_o    = hi_fix;
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [FLAG_N-1:0] flags_i,
    output logic [DATA_W-1:0] acc_o,
    output logic [FLAG_N-1:0] flags_o
);
    alu_op_e           op;
    logic              as_sub;
    logic              as_cin;
    logic [DATA_W-1:0] as_res;
    logic              as_cy;
    logic              as_ac;
    logic [DATA_W-1:0] rot_res;
    logic              rot_cy;
    logic [DATA_W-1:0] da_res;
    logic              da_cy;
    logic              da_ac;
    alu_state_t        st_d;
    alu_state_t        st_q;
    logic [DATA_W-1:0] flag_src;
    logic              szp_en;

    assign op     = alu_op_e'(op_i);
    assign as_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    assign as_cin = ((op == OP_ADC) || (op == OP_SBB)) ? flags_i[FL_CY] : 1'b0;

    alu8_addsub u_addsub (
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .res_o (as_res),
        .cy_o  (as_cy),
        .ac_o  (as_ac)
    );

    alu8_rotate u_rotate (
        .a_i    (acc_i),
        .cy_i   (flags_i[FL_CY]),
        .mode_i (op_i[1:0]),
        .res_o  (rot_res),
        .cy_o   (rot_cy)
    );

    alu8_decadj u_decadj (
        .a_i   (acc_i),
        .cy_i  (flags_i[FL_CY]),
        .ac_i  (flags_i[FL_AUX]),
        .res_o (da_res),
        .cy_o  (da_cy),
        .ac_o  (da_ac)
    );

    always_comb begin
        st_d     = st_q;
        st_d.acc = acc_i;
        st_d.flg = flags_i;
        flag_src = acc_i;
        szp_en   = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                st_d.acc         = as_res;
                st_d.flg[FL_CY]  = as_cy;
                st_d.flg[FL_AUX] = as_ac;
                flag_src         = as_res;
                szp_en           = 1'b1;
            end
            OP_CMP: begin
                st_d.flg[FL_CY]  = as_cy;
                st_d.flg[FL_AUX] = as_ac;
                flag_src         = as_res;
                szp_en           = 1'b1;
            end
            OP_AND: begin
                st_d.acc         = acc_i & opnd_i;
                st_d.flg[FL_CY]  = 1'b0;
                st_d.flg[FL_AUX] = acc_i[NIB_W-1] | opnd_i[NIB_W-1];
                flag_src         = acc_i & opnd_i;
                szp_en           = 1'b1;
            end
            OP_XOR, OP_OR: begin
                st_d.acc         = (op == OP_XOR) ? (acc_i ^ opnd_i) : (acc_i | opnd_i);
                st_d.flg[FL_CY]  = 1'b0;
                st_d.flg[FL_AUX] = 1'b0;
                flag_src         = st_d.acc;
                szp_en           = 1'b1;
            end
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                st_d.acc        = rot_res;
                st_d.flg[FL_CY] = rot_cy;
            end
            OP_CMA: begin
                st_d.acc = ~acc_i;
            end
            OP_STC: begin
                st_d.flg[FL_CY] = 1'b1;
            end
            OP_CMC: begin
                st_d.flg[FL_CY] = ~flags_i[FL_CY];
            end
            OP_DAA: begin
                st_d.acc         = da_res;
                st_d.flg[FL_CY]  = da_cy;
                st_d.flg[FL_AUX] = da_ac;
                flag_src         = da_res;
                szp_en           = 1'b1;
            end
            default: ;
        endcase
        if (szp_en) begin
            st_d.flg[FL_Z]   = (flag_src == '0);
            st_d.flg[FL_S]   = flag_src[DATA_W-1];
            st_d.flg[FL_PAR] = ~(^flag_src);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o   = st_q.acc;
    assign flags_o = st_q.flg;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] acc_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic [FLAG_N-1:0] flags_i,
    input logic [DATA_W-1:0] acc_o,
    input logic [FLAG_N-1:0] flags_o
);
    assert_add_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADD) |=> ({flags_o[FL_CY], acc_o} ==
            ($past({1'b0, acc_i}) + $past({1'b0, opnd_i}))));

    assert_cmp_keeps_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP) |=> (acc_o == $past(acc_i)));

    assert_logic_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_XOR) || (op_i == OP_OR)) |=>
            (!flags_o[FL_CY] && !flags_o[FL_AUX]));

    assert_szp_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i <= OP_OR) || (op_i == OP_DAA)) |=>
            ((flags_o[FL_Z] == (acc_o == '0)) && (flags_o[FL_S] == acc_o[DATA_W-1])
             && (flags_o[FL_PAR] == ~(^acc_o))));

    assert_rot_only_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i >= OP_RLC) && (op_i <= OP_RAR)) |=>
            (flags_o[FLAG_N-1:1] == $past(flags_i[FLAG_N-1:1])));

    assert_cma_no_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMA) |=> ((flags_o == $past(flags_i)) && (acc_o == ~$past(acc_i))));

    assert_stc_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_STC) |=> (flags_o[FL_CY] && (acc_o == $past(acc_i))
            && (flags_o[FLAG_N-1:1] == $past(flags_i[FLAG_N-1:1]))));

    assert_cmc_toggles_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMC) |=> ((flags_o[FL_CY] != $past(flags_i[FL_CY]))
            && (acc_o == $past(acc_i))));

endmodule

bind alu8_core alu8_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .acc_i   (acc_i),
    .opnd_i  (opnd_i),
    .flags_i (flags_i),
    .acc_o   (acc_o),
    .flags_o (flags_o)
);

// File: tb/alu8_core_test.sv
module alu8_core_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] op_i;
    logic [7:0] acc_i;
    logic [7:0] opnd_i;
    logic [4:0] flags_i;
    logic [7:0] acc_o;
    logic [4:0] flags_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    alu8_core uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op_i),
        .acc_i   (acc_i),
        .opnd_i  (opnd_i),
        .flags_i (flags_i),
        .acc_o   (acc_o),
        .flags_o (flags_o)
    );

    function automatic string req_of(input int op);
        case (op)
            0, 1:          return "R2";
            2, 3:          return "R3";
            7:             return "R4";
            4:             return "R5";
            5, 6:          return "R6";
            8, 9, 10, 11:  return "R8";
            12:            return "R9";
            13, 14:        return "R10";
            default:       return "R11";
        endcase
    endfunction

    // result packing: {sign, zero, aux, parity, carry, acc[7:0]}
    function automatic logic [12:0] model(input int op, input int a, input int b,
                                          input logic [4:0] f);
        int r = a;
        int cy = f[0];
        int ac = f[2];
        int c;
        int t;
        bit szp = 1'b0;
        int src;
        logic [4:0] fo = f;
        case (op)
            0, 1: begin
                c  = (op == 1) ? int'(f[0]) : 0;
                t  = a + b + c;
                r  = t % 256;
                cy = (t > 255);
                ac = ((a % 16) + (b % 16) + c) > 15;
                szp = 1'b1; src = r;
            end
            2, 3, 7: begin
                c  = (op == 3) ? int'(f[0]) : 0;
                t  = (a - b - c + 512) % 256;
                cy = (b + c) > a;
                ac = ((b % 16) + c) > (a % 16);
                r  = (op == 7) ? a : t;
                szp = 1'b1; src = t;
            end
            4: begin r = a & b; cy = 0; ac = ((a >> 3) & 1) | ((b >> 3) & 1); szp = 1'b1; src = r; end
            5: begin r = a ^ b; cy = 0; ac = 0; szp = 1'b1; src = r; end
            6: begin r = a | b; cy = 0; ac = 0; szp = 1'b1; src = r; end
            8:  begin cy = a / 128; r = (a * 2) % 256 + cy; end
            9:  begin cy = a % 2;   r = a / 2 + cy * 128; end
            10: begin cy = a / 128; r = (a * 2) % 256 + int'(f[0]); end
            11: begin cy = a % 2;   r = a / 2 + int'(f[0]) * 128; end
            12: r = 255 - a;
            13: cy = 1;
            14: cy = 1 - int'(f[0]);
            default: begin
                c  = (((a % 16) > 9) || f[2]) ? 6 : 0;
                t  = a + c;
                ac = ((a % 16) + c) > 15;
                if (((t % 256) / 16 > 9) || f[0] || (t > 255)) begin
                    cy = 1; r = (t + 96) % 256;
                end else begin
                    cy = 0; r = t % 256;
                end
                szp = 1'b1; src = r;
            end
        endcase
        fo[0] = cy[0];
        fo[2] = ac[0];
        if (szp) begin
            int ones = 0;
            for (int i = 0; i < 8; i++) ones += (src >> i) & 1;
            fo[3] = (src == 0);
            fo[4] = src[7];
            fo[1] = (ones % 2 == 0);
        end
        return {fo, r[7:0]};
    endfunction

    // drives at a falling edge, compares at the next falling edge
    task automatic apply(input int op, input int a, input int b, input logic [4:0] f);
        logic [12:0] exp;
        exp     = model(op, a, b, f);
        op_i    = op[3:0];
        acc_i   = a[7:0];
        opnd_i  = b[7:0];
        flags_i = f;
        @(negedge clk);
        checks++;
        if ({flags_o, acc_o} !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h fin=%b got acc=%h fl=%b exp acc=%h fl=%b",
                     req_of(op), op, a[7:0], b[7:0], f, acc_o, flags_o, exp[7:0], exp[12:8]);
        end
    endtask

    task automatic check_szp_r7();
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += acc_o[i];
        checks++;
        if (flags_o[3] !== (acc_o == 0) || flags_o[4] !== acc_o[7]
            || flags_o[1] !== (ones % 2 == 0)) begin
            errors++;
            $display("FAIL R7 acc=%h got fl=%b exp z=%0d s=%0d p=%0d",
                     acc_o, flags_o, acc_o == 0, acc_o[7], ones % 2 == 0);
        end
    endtask

    initial begin
        #(2_000_000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_i = 4'd0; acc_i = 8'h5A; opnd_i = 8'hA5; flags_i = 5'h1F;
        repeat (3) @(negedge clk);
        checks++;
        if (acc_o !== 8'h00 || flags_o !== 5'h00) begin
            errors++;
            $display("FAIL R1 got acc=%h fl=%b exp acc=00 fl=00000", acc_o, flags_o);
        end
        rst_n = 1'b1;
        op_i = 4'd0; acc_i = 8'h01; opnd_i = 8'h02; flags_i = 5'h00;
        #2;
        checks++;
        if (acc_o !== 8'h00) begin
            errors++;
            $display("FAIL R12 output moved before edge got acc=%h exp acc=00", acc_o);
        end
        @(negedge clk);
        checks++;
        if (acc_o !== 8'h03) begin
            errors++;
            $display("FAIL R12 got acc=%h exp acc=03", acc_o);
        end

        // R2 carry and nibble boundaries
        apply(0, 8'hFF, 8'h01, 5'h00);  check_szp_r7();
        apply(0, 8'h0F, 8'h01, 5'h00);
        apply(1, 8'h7F, 8'h00, 5'h01);
        // R3 borrow cases
        apply(2, 8'h00, 8'h01, 5'h00);
        apply(3, 8'h05, 8'h04, 5'h01);  check_szp_r7();
        apply(3, 8'h10, 8'h00, 5'h01);
        // R4 compare
        apply(7, 8'h33, 8'h33, 5'h00);
        apply(7, 8'h10, 8'h20, 5'h00);
        // R5 / R6
        apply(4, 8'h08, 8'h00, 5'h01);
        apply(5, 8'hAA, 8'hAA, 5'h05);  check_szp_r7();
        apply(6, 8'h80, 8'h01, 5'h05);
        // R8 rotates with both carry values
        for (int op = 8; op <= 11; op++) begin
            apply(op, 8'h81, 8'h00, 5'h00);
            apply(op, 8'h42, 8'h00, 5'h1F);
        end
        // R9 / R10
        apply(12, 8'h3C, 8'h00, 5'h15);
        apply(13, 8'h77, 8'h00, 5'h1A);
        apply(14, 8'h77, 8'h00, 5'h1B);
        apply(14, 8'h77, 8'h00, 5'h0A);
        // R11 decimal adjust corners
        apply(15, 8'h9A, 8'h00, 5'h00);
        apply(15, 8'hFA, 8'h00, 5'h00);
        apply(15, 8'h99, 8'h00, 5'h00);
        apply(15, 8'h15, 8'h00, 5'h04);
        apply(15, 8'h12, 8'h00, 5'h01);
        apply(15, 8'h00, 8'h00, 5'h00);  check_szp_r7();

        // random sweep over every code
        for (int n = 0; n < 300; n++) begin
            for (int op = 0; op < 16; op++) begin
                apply(op, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                      5'($urandom_range(0, 31)));
                if (op <= 6 || op == 15) check_szp_r7();
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule